// File: doc/BRIEF.md
# Receive Ring Page Writer

This block fills a circular packet receive area held in a byte-wide, paged SRAM. The SRAM is cut into 256-byte pages. A byte address is the page number in its upper eight bits followed by the byte offset within the page. Packet bytes arrive one per cycle from the MAC side. The block turns each accepted byte into an SRAM write and moves forward page by page. At the top of the ring it wraps back to the bottom. If moving on would step into the page the host has not yet read, it gives up on the packet.

The ring is described by four 8-bit registers on a small host port:
- the lowest ring page;
- the page one past the top of the ring;
- the host's read page;
- the page where the next packet will be written.

A run bit starts and stops reception. Each stored packet begins with a four-byte header. Packet data goes in behind the header slot. The header itself is written once the packet has ended and its length and follow-on page are known. A finished packet gives a one-cycle "packet stored" pulse. A packet given up for lack of space gives a one-cycle "overwrite" pulse and leaves the write page where it was.

The MAC side is expected to leave at least five idle cycles after the last byte of a packet, which covers the end check and the header write-out.

Top module: `rx_page_ring`

## Requirements
- R1: After reset the host port reads the following values: run bit 0 at offset 0, bit 0; ring bottom page 0x4C at offset 1; ring top (exclusive) 0x80 at offset 2; read page 0x7F at offset 3; write page 0x4C at offset 4. Any other offset reads 0.
- R2: The first byte of a packet is written at offset 4 of the current write page, and each following byte at the next offset. Every accepted byte gives exactly one write (`memWe` high) in the cycle after the byte was presented. The write address is {page, offset}.
- R3: When a packet has filled offset 0xFF of a page and another byte arrives, that byte goes to offset 0 of the following page. If the following page equals the ring top, the ring bottom page is used instead.
- R4: If the page a packet would move into (after the R3 wrap) equals the read page, that byte and all later bytes up to the packet's last byte are dropped. An overwrite pulse appears in the cycle after the dropped byte. No header is written and the write page is unchanged.
- R5: One cycle after the last byte, the page following the last page used (wrapped as in R3) is compared with the read page. If they are equal, the packet is abandoned as in R4, with the overwrite pulse in that cycle.
- R6: Otherwise, starting two cycles after the last byte, four writes go to offsets 0..3 of the packet's first page, one per cycle. They carry, in order: the status byte presented with the last byte; the follow-on page; the length low byte; the length high byte. The length counts the data bytes plus 4.
- R7: Along with the fourth header write, a one-cycle packet-stored pulse appears and the write page (offset 4) takes the follow-on page.
- R8: A packet starts only while the run bit is 1. Bytes presented while idle with run at 0 cause no write and no pulse.
- R9: While the run bit is 1, host writes to offsets 1, 2 and 4 are ignored. The read page at offset 3 can be written at any time, and a write takes effect for comparisons on later cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| regWe | input | 1 | host register write strobe |
| regAddr | input | 3 | host register offset |
| regWdata | input | 8 | host write data |
| regRdata | output | 8 | host read data (combinational on regAddr) |
| macValid | input | 1 | a packet byte is presented |
| macData | input | 8 | packet byte |
| macLast | input | 1 | presented byte is the packet's last |
| macStatus | input | 8 | receive status, taken with the last byte |
| memWe | output | 1 | SRAM write enable |
| memAddr | output | 16 | SRAM byte address {page, offset} |
| memData | output | 8 | SRAM write data |
| pktDone | output | 1 | one-cycle packet-stored pulse |
| ovwWarn | output | 1 | one-cycle overwrite pulse |

## Verification
The host moving the read page and the engine's end-of-packet boundary comparison can land on the same clock edge. The bench provokes this by timing a read-page write so that it is presented together with the cycle after a packet's last byte. Before that write the old read page equals the follow-on page; the write itself moves the read page out of the way. The packet must still be abandoned, because the comparison uses the old value, and the read-back must show the new read page afterwards. A behavioural model in the bench predicts every write, pulse and register value cycle by cycle, so the sequencing of the last data write, the end check and the four header writes is judged on each clock.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int HDR_LEN = 4;
  localparam int BYTE_W  = 8;

  localparam logic [2:0] OFS_CTRL     = 3'd0;
  localparam logic [2:0] OFS_RING_LO  = 3'd1;
  localparam logic [2:0] OFS_RING_HI  = 3'd2;
  localparam logic [2:0] OFS_READ_PG  = 3'd3;
  localparam logic [2:0] OFS_WRITE_PG = 3'd4;

  typedef enum logic [2:0] {ST_IDLE, ST_DATA, ST_DROP, ST_END, ST_HDR} ringState_t;

  typedef struct packed {
    logic       startPkt;
    logic       wrByte;
    logic       advPage;
    logic       seal;
    logic       wrHdr;
    logic [1:0] hdrIdx;
    logic       commit;
    logic       abort;
  } ringStrobe_t;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        macValid,
  input  logic        macLast,
  input  logic        runEn,
  input  logic        pageEnd,
  input  logic        nextIsRead,
  output ringStrobe_t stb
);
  ringState_t state, stateNxt;
  logic [1:0] hdrCnt;

  always_comb begin
    stb        = '0;
    stb.hdrIdx = hdrCnt;
    stateNxt   = state;
    unique case (state)
      ST_IDLE: if (macValid && runEn) begin
        stb.startPkt = 1'b1;
        stateNxt     = macLast ? ST_END : ST_DATA;
      end
      ST_DATA: if (macValid) begin
        if (pageEnd && nextIsRead) begin
          stb.abort = 1'b1;
          stateNxt  = macLast ? ST_IDLE : ST_DROP;
        end else begin
          stb.wrByte  = 1'b1;
          stb.advPage = pageEnd;
          if (macLast) stateNxt = ST_END;
        end
      end
      ST_DROP: if (macValid && macLast) stateNxt = ST_IDLE;
      ST_END: begin
        if (nextIsRead) begin
          stb.abort = 1'b1;
          stateNxt  = ST_IDLE;
        end else begin
          stb.seal = 1'b1;
          stateNxt = ST_HDR;
        end
      end
      ST_HDR: begin
        stb.wrHdr = 1'b1;
        if (hdrCnt == 2'(HDR_LEN - 1)) begin
          stb.commit = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrCnt <= '0;
    end else begin
      state  <= stateNxt;
      hdrCnt <= (state == ST_HDR) ? hdrCnt + 2'd1 : 2'd0;
    end
  end

  // R8: no packet may begin while reception is stopped
  a_r8_stopped_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !runEn) |=> (state == ST_IDLE));
endmodule

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int REG_AW = 3,
  parameter logic [PAGE_W-1:0] RING_LO_RST = 8'h4C,
  parameter logic [PAGE_W-1:0] RING_HI_RST = 8'h80,
  parameter logic [PAGE_W-1:0] READ_PG_RST = 8'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       stb,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [PAGE_W-1:0] regWdata,
  output logic [PAGE_W-1:0] regRdata,
  input  logic [BYTE_W-1:0] macData,
  input  logic              macLast,
  input  logic [BYTE_W-1:0] macStatus,
  output logic              runEn,
  output logic              pageEnd,
  output logic              nextIsRead,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memData,
  output logic              pktDone,
  output logic              ovwWarn
);
  localparam int OFF_W = ADDR_W - PAGE_W;
  localparam int LEN_W = 2 * BYTE_W;

  logic              runQ;
  logic [PAGE_W-1:0] ringLo, ringHi, readPg, writePg;
  logic [PAGE_W-1:0] curPg, firstPg, nextPtr, incPg, linkPg;
  logic [OFF_W-1:0]  byteOff;
  logic [LEN_W-1:0]  pktLen;
  logic [BYTE_W-1:0] statQ, hdrByte;

  assign incPg      = curPg + 1'b1;
  assign linkPg     = (incPg == ringHi) ? ringLo : incPg;
  assign nextIsRead = (linkPg == readPg);
  assign pageEnd    = (byteOff == '0);
  assign runEn      = runQ;

  always_comb begin
    unique case (stb.hdrIdx)
      2'd0:    hdrByte = statQ;
      2'd1:    hdrByte = BYTE_W'(nextPtr);
      2'd2:    hdrByte = pktLen[BYTE_W-1:0];
      default: hdrByte = pktLen[LEN_W-1:BYTE_W];
    endcase
  end

  always_comb begin
    case (regAddr)
      OFS_CTRL:     regRdata = {{(PAGE_W-1){1'b0}}, runQ};
      OFS_RING_LO:  regRdata = ringLo;
      OFS_RING_HI:  regRdata = ringHi;
      OFS_READ_PG:  regRdata = readPg;
      OFS_WRITE_PG: regRdata = writePg;
      default:      regRdata = '0;
    endcase
  end

  // ring registers: geometry locked while running, read page always open
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      ringLo  <= RING_LO_RST;
      ringHi  <= RING_HI_RST;
      readPg  <= READ_PG_RST;
      writePg <= RING_LO_RST;
    end else begin
      if (regWe && regAddr == OFS_CTRL)            runQ   <= regWdata[0];
      if (regWe && !runQ && regAddr == OFS_RING_LO) ringLo <= regWdata;
      if (regWe && !runQ && regAddr == OFS_RING_HI) ringHi <= regWdata;
      if (regWe && regAddr == OFS_READ_PG)         readPg <= regWdata;
      if (stb.commit)                              writePg <= nextPtr;
      else if (regWe && !runQ && regAddr == OFS_WRITE_PG) writePg <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
      pktDone <= 1'b0;
      ovwWarn <= 1'b0;
      curPg   <= '0;
      firstPg <= '0;
      nextPtr <= '0;
      byteOff <= '0;
      pktLen  <= '0;
      statQ   <= '0;
    end else begin
      memWe   <= 1'b0;
      pktDone <= stb.commit;
      ovwWarn <= stb.abort;
      if (stb.startPkt) begin
        curPg   <= writePg;
        firstPg <= writePg;
        memWe   <= 1'b1;
        memAddr <= {writePg, OFF_W'(HDR_LEN)};
        memData <= macData;
        byteOff <= OFF_W'(HDR_LEN + 1);
        pktLen  <= LEN_W'(HDR_LEN + 1);
      end
      if (stb.wrByte) begin
        memWe   <= 1'b1;
        memAddr <= {(stb.advPage ? linkPg : curPg), byteOff};
        memData <= macData;
        byteOff <= byteOff + 1'b1;
        pktLen  <= pktLen + 1'b1;
        if (stb.advPage) curPg <= linkPg;
      end
      if ((stb.startPkt || stb.wrByte) && macLast) statQ <= macStatus;
      if (stb.seal) nextPtr <= linkPg;
      if (stb.wrHdr) begin
        memWe   <= 1'b1;
        memAddr <= {firstPg, OFF_W'(stb.hdrIdx)};
        memData <= hdrByte;
      end
    end
  end

  // R4: an abandoned packet issues no write in the cycle it is dropped
  a_r4_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ovwWarn |-> !memWe);
  // R4/R7: a packet ends in exactly one way
  a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(pktDone && ovwWarn));
  // R7: the stored pulse rides on the last header byte
  a_r7_done_on_hdr: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (memWe && memAddr[OFF_W-1:0] == OFF_W'(HDR_LEN - 1)));
  // R7: while running the write page moves only on commit
  a_r7_wp_commit_only: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !stb.commit) |=> $stable(writePg));
  // R9: ring geometry frozen while running
  a_r9_geometry_locked: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> ($stable(ringLo) && $stable(ringHi)));
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [PAGE_W-1:0] regWdata,
  output logic [PAGE_W-1:0] regRdata,
  input  logic              macValid,
  input  logic [BYTE_W-1:0] macData,
  input  logic              macLast,
  input  logic [BYTE_W-1:0] macStatus,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memData,
  output logic              pktDone,
  output logic              ovwWarn
);
  ringStrobe_t stb;
  logic runEn, pageEnd, nextIsRead;

  rx_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .macValid(macValid), .macLast(macLast),
    .runEn(runEn), .pageEnd(pageEnd), .nextIsRead(nextIsRead), .stb(stb)
  );

  rx_ring_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .macData(macData), .macLast(macLast), .macStatus(macStatus),
    .runEn(runEn), .pageEnd(pageEnd), .nextIsRead(nextIsRead),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .pktDone(pktDone), .ovwWarn(ovwWarn)
  );
endmodule

// File: tb/tb_rx_page_ring.sv
module tb_rx_page_ring;
  logic clk = 1'b0;
  logic rstN;
  logic regWe;
  logic [2:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic macValid, macLast;
  logic [7:0] macData, macStatus;
  logic memWe, pktDone, ovwWarn;
  logic [15:0] memAddr;
  logic [7:0] memData;

  always #5 clk = ~clk;

  rx_page_ring dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .macValid(macValid), .macData(macData), .macLast(macLast),
    .macStatus(macStatus), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .pktDone(pktDone), .ovwWarn(ovwWarn)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit ended   = 0;

  // behavioural model state
  int mRun = 0, mLo = 'h4C, mHi = 'h80, mRd = 'h7F, mCur = 'h4C;
  int mMode = 0;  // 0 idle, 1 taking data, 2 dropping, 3 end check, 4 header
  int mPg, mOff, mFirst, mLen, mStat, mNxt, mK;
  int eWe, eAddr, eData, eDone, eOvw;
  string tag;

  function automatic int wrapNext(int p);
    int n = (p + 1) & 255;
    return (n == mHi) ? mLo : n;
  endfunction

  task automatic modelStep();
    int preRun = mRun;
    bit committed = 0;
    eWe = 0; eAddr = 0; eData = 0; eDone = 0; eOvw = 0; tag = "R2";
    case (mMode)
      0: if (macValid) begin
        if (mRun == 1) begin
          mFirst = mCur; mPg = mCur;
          eWe = 1; eAddr = mCur * 256 + 4; eData = macData;
          mOff = 5; mLen = 5;
          if (macLast) begin mStat = macStatus; mMode = 3; end else mMode = 1;
        end else tag = "R8";
      end
      1: if (macValid) begin
        if (mOff == 0 && wrapNext(mPg) == mRd) begin
          tag = "R4"; eOvw = 1; mMode = macLast ? 0 : 2;
        end else begin
          if (mOff == 0) begin mPg = wrapNext(mPg); tag = "R3"; end
          eWe = 1; eAddr = mPg * 256 + mOff; eData = macData;
          mOff = (mOff + 1) & 255; mLen++;
          if (macLast) begin mStat = macStatus; mMode = 3; end
        end
      end
      2: begin tag = "R4"; if (macValid && macLast) mMode = 0; end
      3: begin
        tag = "R5";
        if (wrapNext(mPg) == mRd) begin eOvw = 1; mMode = 0; end
        else begin mNxt = wrapNext(mPg); mMode = 4; mK = 0; end
      end
      default: begin
        tag = "R6";
        eWe = 1; eAddr = mFirst * 256 + mK;
        case (mK)
          0: eData = mStat;
          1: eData = mNxt;
          2: eData = mLen & 255;
          default: eData = (mLen >> 8) & 255;
        endcase
        if (mK == 3) begin
          tag = "R7"; eDone = 1; mCur = mNxt; committed = 1; mMode = 0;
        end else mK++;
      end
    endcase
    if (regWe) begin
      case (regAddr)
        3'd0: mRun = regWdata[0];
        3'd1: if (preRun == 0) mLo = regWdata;
        3'd2: if (preRun == 0) mHi = regWdata;
        3'd3: mRd = regWdata;
        3'd4: if (preRun == 0 && !committed) mCur = regWdata;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    if (rstN === 1'b1 && !ended) begin
      modelStep();
      nChecks++;
      if (memWe !== eWe[0] || pktDone !== eDone[0] || ovwWarn !== eOvw[0] ||
          (eWe == 1 && (memAddr !== eAddr[15:0] || memData !== eData[7:0]))) begin
        nFails++;
        $display("FAIL %s cycle %0d: we=%0b/%0b addr=%h/%h data=%h/%h done=%0b/%0b ovw=%0b/%0b (actual/expected)",
                 tag, cyc, memWe, eWe[0], memAddr, eAddr[15:0], memData, eData[7:0],
                 pktDone, eDone[0], ovwWarn, eOvw[0]);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000 && !ended) begin
      ended = 1;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 60000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic rdChk(input logic [2:0] a, input logic [7:0] exp, input string rq);
    regAddr = a;
    #1;
    nChecks++;
    if (regRdata !== exp) begin
      nFails++;
      $display("FAIL %s read offset %0d: actual %h expected %h", rq, a, regRdata, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic sendPkt(input int n, input logic [7:0] st, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      macValid = 1'b1; macData = 8'((i * 7 + seed) & 255);
      macLast = (i == n - 1); macStatus = st;
    end
    @(negedge clk);
    macValid = 1'b0; macLast = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    macValid = 1'b0; macLast = 1'b0; macData = '0; macStatus = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rdChk(3'd0, 8'h00, "R1"); rdChk(3'd1, 8'h4C, "R1"); rdChk(3'd2, 8'h80, "R1");
    rdChk(3'd3, 8'h7F, "R1"); rdChk(3'd4, 8'h4C, "R1"); rdChk(3'd6, 8'h00, "R1");
    wr(3'd0, 8'h01);
    sendPkt(60, 8'h01, 3);              // R2 single page
    rdChk(3'd4, 8'h4D, "R7");
    sendPkt(600, 8'h21, 9);             // R3 spans three pages
    rdChk(3'd4, 8'h50, "R3");
    wr(3'd1, 8'h20);                    // R9 locked while running
    rdChk(3'd1, 8'h4C, "R9");
    wr(3'd3, 8'h60);
    rdChk(3'd3, 8'h60, "R9");
    wr(3'd0, 8'h00);
    sendPkt(20, 8'h01, 5);              // R8 stopped: nothing written
    rdChk(3'd4, 8'h50, "R8");
    wr(3'd4, 8'h7E); wr(3'd3, 8'h4E); wr(3'd0, 8'h01);
    sendPkt(300, 8'h41, 11);            // R3 wrap top -> bottom
    rdChk(3'd4, 8'h4C, "R3");
    sendPkt(10, 8'h01, 2);
    rdChk(3'd4, 8'h4D, "R6");
    sendPkt(10, 8'h03, 4);              // R5 end check hits read page
    rdChk(3'd4, 8'h4D, "R5");
    sendPkt(300, 8'h05, 6);             // R4 link hits read page
    rdChk(3'd4, 8'h4D, "R4");
    wr(3'd3, 8'h50);
    sendPkt(300, 8'h07, 8);
    rdChk(3'd4, 8'h4F, "R7");
    sendPkt(252, 8'h09, 1);             // R5 exact page fill, next is read page
    rdChk(3'd4, 8'h4F, "R5");
    wr(3'd3, 8'h7F);
    sendPkt(252, 8'h0B, 12);
    rdChk(3'd4, 8'h50, "R6");
    sendPkt(253, 8'h0D, 13);            // R3 link on the last byte
    rdChk(3'd4, 8'h52, "R3");
    wr(3'd3, 8'h53);
    fork
      sendPkt(20, 8'h0F, 14);           // R9 read-page write on the end-check edge
      begin
        repeat (21) @(negedge clk);
        regWe = 1'b1; regAddr = 3'd3; regWdata = 8'h7F;
        @(negedge clk);
        regWe = 1'b0;
      end
    join
    rdChk(3'd4, 8'h52, "R9");
    rdChk(3'd3, 8'h7F, "R9");
    sendPkt(20, 8'h11, 15);
    rdChk(3'd4, 8'h53, "R7");
    repeat (4) @(negedge clk);
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule